// File: doc/BRIEF.md
# Compare, Negate and Extend Unit

This block is the execution slice for a small family of single-operand and two-operand integer operations on a general register value. It performs compare, two's-complement negate, zero-extend and sign-extend. It also performs an atomic-style test-and-set on one memory byte. The operand size is chosen per operation: byte, word or longword. The unit keeps the four condition-code flags (N, Z, V, C) in its own register and presents them on a port.

A register operation is accepted in a cycle where `op_valid` is high and `busy` is low. Its result, write enable and flags appear one clock later with a one-cycle `res_valid` pulse. A test-and-set goes through a read-modify-write sequence on a simple request/valid memory handshake. `busy` stays high until the write is accepted. Any operation or size combination that is not permitted returns an `res_illegal` pulse and leaves all state untouched.

Top module: `cne_unit`

## Requirements
- R1: Compare (op_code 0) subtracts the source (`src_opnd`, or `imm_opnd` when `src_is_imm`=1) from `dst_opnd` at the active size. It updates only the flags, and `res_wr_en` stays 0.
- R2: Negate (op_code 1) gives 0 minus `dst_opnd` at the active size with `res_wr_en`=1. Bits above the active size are taken unchanged from `dst_opnd`.
- R3: For compare and negate, the flags are set as follows: N is the result MSB at the active size, Z=1 when the sized result is zero, V is the signed overflow of the subtraction and C is the borrow out of the active size. `ccr_flags` is {N,Z,V,C} from bit 3 down to bit 0.
- R4: Zero-extend (op_code 2) at word size (size 1) clears bits 15:8 and keeps bits 31:16 and 7:0 of `dst_opnd`. At longword size (size 2) it clears bits 31:16 and keeps bits 15:0. `res_wr_en`=1.
- R5: Sign-extend (op_code 3) fills bits 15:8 with bit 7 at word size. At longword size it fills bits 31:16 with bit 15. Other bits are as in R4.
- R6: Extension sets N and Z from the extended value at the active size, clears V and leaves C unchanged.
- R7: An accepted register operation gives `res_valid` high for exactly one cycle, on the clock edge after acceptance.
- R8: The following combinations are illegal: size code 3, extension at byte size (size 0), test-and-set at any size other than byte, and op codes 5 to 7. An illegal combination gives `res_valid`=1 with `res_illegal`=1 and `res_wr_en`=0, and leaves the flags unchanged.
- R9: Test-and-set (op_code 4) is permitted only with pointer register index 0, 1, 4 or 5. Any other index is illegal as in R8 and starts no memory access.
- R10: Test-and-set raises `mem_rd_req` with `mem_addr`=`ptr_addr` and holds both until `mem_rd_valid`.
- R11: After the read, `mem_wr_req` is held with `mem_wdata` = old byte with bit 7 set, until `mem_wr_ready`. The next edge then gives a `res_valid` pulse with `res_wr_en`=0.
- R12: Test-and-set completion sets N to bit 7 of the old byte and Z=1 when the old byte was zero, and clears V and C.
- R13: While `busy` is high, `op_valid` is ignored: it gives no result pulse and does not touch the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 3 | 0 cmp, 1 neg, 2 zero-ext, 3 sign-ext, 4 test-and-set |
| op_size | input | 2 | 0 byte, 1 word, 2 longword |
| src_is_imm | input | 1 | Compare uses the immediate as source |
| dst_opnd | input | 32 | Destination operand |
| src_opnd | input | 32 | Source register operand |
| imm_opnd | input | 32 | Immediate operand |
| ptr_idx | input | 3 | Register index holding the test-and-set address |
| ptr_addr | input | 16 | Test-and-set byte address |
| busy | output | 1 | Test-and-set in progress |
| res_valid | output | 1 | Result pulse |
| res_wr_en | output | 1 | Result should be written to the destination |
| res_data | output | 32 | Result value |
| res_illegal | output | 1 | Operation rejected |
| ccr_flags | output | 4 | {N,Z,V,C} |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_rd_valid | input | 1 | Read data valid |
| mem_wr_ready | input | 1 | Write accepted |

## Verification
A register operation and a test-and-set can collide when a negate or compare is offered while the memory write is stalled. The bench provokes this by holding `mem_wr_ready` low for several cycles and raising `op_valid` with a negate in the middle of the stall. It then checks at the ports that no result pulse appears, that `mem_wr_req` and `mem_wdata` hold, and that the flags seen after completion come only from the old memory byte.

// File: rtl/cne_pkg.sv
package cne_pkg;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_NEG  = 3'd1,
        OP_EXTU = 3'd2,
        OP_EXTS = 3'd3,
        OP_TSET = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_WRITE = 2'd2
    } tset_state_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

endpackage

// File: rtl/cne_sub.sv
module cne_sub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] diff,
    output logic [3:0]        nzvc
);
    localparam int NLANE = 3;

    logic [DATA_W-1:0] lane_diff [NLANE];
    logic [3:0]        lane_flag [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = 8 << g;
        logic [LW:0] wide;
        always_comb begin
            wide = {1'b0, lhs[LW-1:0]} - {1'b0, rhs[LW-1:0]};
            lane_diff[g] = DATA_W'(wide[LW-1:0]);
            lane_flag[g][3] = wide[LW-1];
            lane_flag[g][2] = (wide[LW-1:0] == '0);
            lane_flag[g][1] = (lhs[LW-1] ^ rhs[LW-1]) & (lhs[LW-1] ^ wide[LW-1]);
            lane_flag[g][0] = wide[LW];
        end
    end

    always_comb begin
        case (size)
            2'd0:    begin diff = lane_diff[0]; nzvc = lane_flag[0]; end
            2'd1:    begin diff = lane_diff[1]; nzvc = lane_flag[1]; end
            default: begin diff = lane_diff[2]; nzvc = lane_flag[2]; end
        endcase
    end
endmodule

// File: rtl/cne_ext.sv
module cne_ext #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  logic              to_long,
    input  logic              sign_mode,
    output logic [DATA_W-1:0] ext,
    output logic              neg,
    output logic              zero
);
    localparam int QW = DATA_W / 4;
    localparam int HW = DATA_W / 2;

    logic fill;

    always_comb begin
        if (to_long) begin
            fill = sign_mode & src[HW-1];
            ext  = {{HW{fill}}, src[HW-1:0]};
            neg  = ext[DATA_W-1];
            zero = (ext == '0);
        end else begin
            fill = sign_mode & src[QW-1];
            ext  = {src[DATA_W-1:HW], {QW{fill}}, src[QW-1:0]};
            neg  = ext[HW-1];
            zero = (ext[HW-1:0] == '0);
        end
    end
endmodule

// File: rtl/cne_legal.sv
module cne_legal #(
    parameter int                IDX_W       = 3,
    parameter logic [2**IDX_W-1:0] PTR_OK_MASK = 8'h33
) (
    input  logic [2:0]       op,
    input  logic [1:0]       size,
    input  logic [IDX_W-1:0] idx,
    output logic             ok
);
    import cne_pkg::*;

    always_comb begin
        case (op)
            OP_CMP, OP_NEG:   ok = (size != SZ_BAD);
            OP_EXTU, OP_EXTS: ok = (size == SZ_WORD) || (size == SZ_LONG);
            OP_TSET:          ok = (size == SZ_BYTE) && PTR_OK_MASK[idx];
            default:          ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/cne_unit.sv
module cne_unit #(
    parameter int                  DATA_W      = 32,
    parameter int                  ADDR_W      = 16,
    parameter int                  IDX_W       = 3,
    parameter logic [2**IDX_W-1:0] PTR_OK_MASK = 8'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic              src_is_imm,
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic [DATA_W-1:0] imm_opnd,
    input  logic [IDX_W-1:0]  ptr_idx,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic              busy,
    output logic              res_valid,
    output logic              res_wr_en,
    output logic [DATA_W-1:0] res_data,
    output logic              res_illegal,
    output logic [3:0]        ccr_flags,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rd_valid,
    input  logic              mem_wr_ready
);
    import cne_pkg::*;

    localparam int QW = DATA_W / 4;
    localparam int HW = DATA_W / 2;

    typedef struct packed {
        tset_state_e       state;
        logic              valid;
        logic              wr_en;
        logic              illegal;
        logic [DATA_W-1:0] data;
        logic [3:0]        flags;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        old_byte;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic [DATA_W-1:0] sub_lhs, sub_rhs, sub_diff;
    logic [3:0]        sub_flags;
    logic [DATA_W-1:0] ext_val;
    logic              ext_n, ext_z;
    logic              legal;
    logic              is_neg;
    logic [DATA_W-1:0] neg_merged;

    assign is_neg  = (op_code == OP_NEG);
    assign sub_lhs = is_neg ? '0 : dst_opnd;
    assign sub_rhs = is_neg ? dst_opnd : (src_is_imm ? imm_opnd : src_opnd);

    cne_sub #(.DATA_W(DATA_W)) u_sub (
        .lhs  (sub_lhs),
        .rhs  (sub_rhs),
        .size (op_size),
        .diff (sub_diff),
        .nzvc (sub_flags)
    );

    cne_ext #(.DATA_W(DATA_W)) u_ext (
        .src       (dst_opnd),
        .to_long   (op_size == SZ_LONG),
        .sign_mode (op_code == OP_EXTS),
        .ext       (ext_val),
        .neg       (ext_n),
        .zero      (ext_z)
    );

    cne_legal #(.IDX_W(IDX_W), .PTR_OK_MASK(PTR_OK_MASK)) u_legal (
        .op   (op_code),
        .size (op_size),
        .idx  (ptr_idx),
        .ok   (legal)
    );

    always_comb begin
        case (op_size)
            SZ_BYTE: neg_merged = {dst_opnd[DATA_W-1:QW], sub_diff[QW-1:0]};
            SZ_WORD: neg_merged = {dst_opnd[DATA_W-1:HW], sub_diff[HW-1:0]};
            default: neg_merged = sub_diff;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    if (!legal) begin
                        st_d.valid   = 1'b1;
                        st_d.illegal = 1'b1;
                    end else begin
                        case (op_code)
                            OP_CMP: begin
                                st_d.valid = 1'b1;
                                st_d.data  = neg_merged;
                                st_d.flags = sub_flags;
                            end
                            OP_NEG: begin
                                st_d.valid = 1'b1;
                                st_d.wr_en = 1'b1;
                                st_d.data  = neg_merged;
                                st_d.flags = sub_flags;
                            end
                            OP_EXTU, OP_EXTS: begin
                                st_d.valid = 1'b1;
                                st_d.wr_en = 1'b1;
                                st_d.data  = ext_val;
                                st_d.flags = {ext_n, ext_z, 1'b0, st_q.flags[FLAG_C]};
                            end
                            default: begin
                                st_d.state = ST_READ;
                                st_d.addr  = ptr_addr;
                            end
                        endcase
                    end
                end
            end
            ST_READ: begin
                if (mem_rd_valid) begin
                    st_d.old_byte = mem_rdata;
                    st_d.state    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_wr_ready) begin
                    st_d.state = ST_IDLE;
                    st_d.valid = 1'b1;
                    st_d.flags = {st_q.old_byte[7], (st_q.old_byte == 8'h00), 2'b00};
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.state != ST_IDLE);
    assign res_valid   = st_q.valid;
    assign res_wr_en   = st_q.wr_en;
    assign res_data    = st_q.data;
    assign res_illegal = st_q.illegal;
    assign ccr_flags   = st_q.flags;
    assign mem_rd_req  = (st_q.state == ST_READ);
    assign mem_wr_req  = (st_q.state == ST_WRITE);
    assign mem_addr    = st_q.addr;
    assign mem_wdata   = st_q.old_byte | 8'h80;

endmodule

// File: rtl/cne_unit_chk.sv
module cne_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic              busy,
    input logic              res_valid,
    input logic              res_wr_en,
    input logic              res_illegal,
    input logic [3:0]        ccr_flags,
    input logic              mem_rd_req,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_rd_valid,
    input logic              mem_wr_ready
);
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_addr));

    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && !mem_wr_ready |=> mem_wr_req && $stable(mem_wdata));

    assert_wbit7_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wdata[7]);

    assert_tset_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && mem_wr_ready |=> res_valid && !res_wr_en && (ccr_flags[1:0] == 2'b00));

    assert_illegal_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> res_valid && !res_wr_en && $stable(ccr_flags));

    assert_ext_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !busy && (op_code[2:1] == 2'b01) |=>
            res_illegal || (!ccr_flags[1] && ccr_flags[0] == $past(ccr_flags[0])));

    assert_busy_ignore_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_wr_req |=> !res_valid);

    assert_illegal_nomem_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> !mem_rd_req && !mem_wr_req);
endmodule

bind cne_unit cne_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .busy         (busy),
    .res_valid    (res_valid),
    .res_wr_en    (res_wr_en),
    .res_illegal  (res_illegal),
    .ccr_flags    (ccr_flags),
    .mem_rd_req   (mem_rd_req),
    .mem_wr_req   (mem_wr_req),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/cne_unit_tb.sv
module cne_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [1:0]  op_size;
    logic        src_is_imm;
    logic [31:0] dst_opnd, src_opnd, imm_opnd;
    logic [2:0]  ptr_idx;
    logic [15:0] ptr_addr;
    logic        busy, res_valid, res_wr_en, res_illegal;
    logic [31:0] res_data;
    logic [3:0]  ccr_flags;
    logic        mem_rd_req, mem_wr_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_rd_valid, mem_wr_ready;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cne_unit u_dut (.*);

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  size;
        logic        imm;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] immv;
        logic [31:0] exp_data;
        logic        exp_we;
        logic [3:0]  exp_flags;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 1'b0, 32'h00000005, 32'h00000005, 32'h0, 32'h0, 1'b0, 4'h4},
        '{3'd0, 2'd0, 1'b0, 32'h00000003, 32'h00000005, 32'h0, 32'h0, 1'b0, 4'h9},
        '{3'd0, 2'd0, 1'b1, 32'h00000080, 32'h000000FF, 32'h1, 32'h0, 1'b0, 4'h2},
        '{3'd0, 2'd1, 1'b0, 32'h12347FFF, 32'h0000FFFF, 32'h0, 32'h0, 1'b0, 4'hB},
        '{3'd0, 2'd2, 1'b0, 32'h00000000, 32'h00000001, 32'h0, 32'h0, 1'b0, 4'h9},
        '{3'd1, 2'd0, 1'b0, 32'hAABBCC01, 32'h0, 32'h0, 32'hAABBCCFF, 1'b1, 4'h9},
        '{3'd1, 2'd1, 1'b0, 32'h00008000, 32'h0, 32'h0, 32'h00008000, 1'b1, 4'hB},
        '{3'd2, 2'd1, 1'b0, 32'h123456F0, 32'h0, 32'h0, 32'h123400F0, 1'b1, 4'h1},
        '{3'd3, 2'd1, 1'b0, 32'h000000F0, 32'h0, 32'h0, 32'h0000FFF0, 1'b1, 4'h9},
        '{3'd3, 2'd2, 1'b0, 32'hFFFF7FFF, 32'h0, 32'h0, 32'h00007FFF, 1'b1, 4'h1},
        '{3'd2, 2'd2, 1'b0, 32'hABCD0000, 32'h0, 32'h0, 32'h00000000, 1'b1, 4'h5},
        '{3'd1, 2'd2, 1'b0, 32'h00000000, 32'h0, 32'h0, 32'h00000000, 1'b1, 4'h4},
        '{3'd1, 2'd2, 1'b0, 32'h80000000, 32'h0, 32'h0, 32'h80000000, 1'b1, 4'hB}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic imm,
                         input logic [31:0] d, input logic [31:0] s, input logic [31:0] iv,
                         input logic [2:0] idx, input logic [15:0] ad);
        op_code = op; op_size = sz; src_is_imm = imm; dst_opnd = d; src_opnd = s;
        imm_opnd = iv; ptr_idx = idx; ptr_addr = ad; op_valid = 1'b1;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [2:0] idx);
        @(negedge clk);
        drive(op, sz, 1'b0, 32'h0000_00F0, 32'h0, 32'h0, idx, 16'h0040);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_size = '0; src_is_imm = 1'b0;
        dst_opnd = '0; src_opnd = '0; imm_opnd = '0; ptr_idx = '0; ptr_addr = '0;
        mem_rdata = '0; mem_rd_valid = 1'b0; mem_wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "reset res_valid", {31'b0, res_valid}, 32'h0);
        chk("R3", "reset flags", {28'b0, ccr_flags}, 32'h0);
        chk("R10", "reset mem req", {30'b0, mem_rd_req, mem_wr_req}, 32'h0);
        chk("R13", "reset busy", {31'b0, busy}, 32'h0);

        // R1 R2 R3 R4 R5 R6 R7: vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].size, VECS[i].imm, VECS[i].dst, VECS[i].src,
                  VECS[i].immv, 3'd0, 16'h0);
            @(negedge clk);
            op_valid = 1'b0;
            chk("R7", $sformatf("vec%0d valid", i), {31'b0, res_valid}, 32'h1);
            chk(VECS[i].op == 3'd0 ? "R1" : (VECS[i].op == 3'd1 ? "R2" : "R4"),
                $sformatf("vec%0d wr_en", i), {31'b0, res_wr_en}, {31'b0, VECS[i].exp_we});
            chk(VECS[i].op[1] ? "R6" : "R3", $sformatf("vec%0d flags", i),
                {28'b0, ccr_flags}, {28'b0, VECS[i].exp_flags});
            if (VECS[i].exp_we)
                chk(VECS[i].op == 3'd3 ? "R5" : (VECS[i].op == 3'd2 ? "R4" : "R2"),
                    $sformatf("vec%0d data", i), res_data, VECS[i].exp_data);
            @(negedge clk);
            chk("R7", $sformatf("vec%0d pulse end", i), {31'b0, res_valid}, 32'h0);
        end

        // R8: illegal combinations keep flags (0xB from last vector)
        issue(3'd2, 2'd0, 3'd0);
        chk("R8", "ext byte illegal", {30'b0, res_illegal, res_wr_en}, 32'h2);
        chk("R8", "ext byte flags kept", {28'b0, ccr_flags}, 32'hB);
        issue(3'd0, 2'd3, 3'd0);
        chk("R8", "size 3 illegal", {31'b0, res_illegal}, 32'h1);
        issue(3'd6, 2'd0, 3'd0);
        chk("R8", "opcode 6 illegal", {31'b0, res_illegal}, 32'h1);
        issue(3'd4, 2'd1, 3'd4);
        chk("R8", "tset word illegal", {31'b0, res_illegal}, 32'h1);

        // R9: bad pointer index
        issue(3'd4, 2'd0, 3'd2);
        chk("R9", "tset idx2 illegal", {31'b0, res_illegal}, 32'h1);
        @(negedge clk);
        chk("R9", "tset idx2 no read", {30'b0, mem_rd_req, busy}, 32'h0);
        chk("R9", "flags kept", {28'b0, ccr_flags}, 32'hB);

        // R10 R11 R12 R13: tset on zero byte with read wait and write stall
        issue(3'd4, 2'd0, 3'd4);
        chk("R10", "rd req", {31'b0, mem_rd_req}, 32'h1);
        chk("R10", "addr", {16'b0, mem_addr}, 32'h0040);
        @(negedge clk);
        chk("R10", "rd req held", {31'b0, mem_rd_req}, 32'h1);
        mem_rd_valid = 1'b1; mem_rdata = 8'h00;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R11", "wr req", {30'b0, mem_wr_req, mem_rd_req}, 32'h2);
        chk("R11", "wdata", {24'b0, mem_wdata}, 32'h80);
        drive(3'd1, 2'd2, 1'b0, 32'h5, 32'h0, 32'h0, 3'd0, 16'h0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R13", "collided neg ignored", {31'b0, res_valid}, 32'h0);
        chk("R11", "wr held in stall", {31'b0, mem_wr_req}, 32'h1);
        chk("R13", "flags untouched in stall", {28'b0, ccr_flags}, 32'hB);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        chk("R11", "tset done", {29'b0, res_valid, res_wr_en, busy}, 32'h4);
        chk("R12", "tset zero flags", {28'b0, ccr_flags}, 32'h4);
        @(negedge clk);
        chk("R7", "tset pulse end", {31'b0, res_valid}, 32'h0);

        // R12: tset on negative byte, permitted index 1
        issue(3'd4, 2'd0, 3'd1);
        mem_rd_valid = 1'b1; mem_rdata = 8'h93;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R11", "wdata keep bit7", {24'b0, mem_wdata}, 32'h93);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        chk("R12", "tset neg flags", {28'b0, ccr_flags}, 32'h8);

        // R11: positive byte gets bit7 set
        issue(3'd4, 2'd0, 3'd5);
        mem_rd_valid = 1'b1; mem_rdata = 8'h05;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        chk("R11", "wdata set bit7", {24'b0, mem_wdata}, 32'h85);
        mem_wr_ready = 1'b1;
        @(negedge clk);
        mem_wr_ready = 1'b0;
        chk("R12", "tset pos flags", {28'b0, ccr_flags}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule